// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO

This block buffers 18-bit words between two clock domains whose clocks run freely and may be unrelated or identical. A producer in the write domain offers a word together with two write qualifiers of opposite polarity. The word is taken only while the block reports room on `in_rdy`. The read side has no separate fetch step. As soon as a word is stored, it moves into an output register by itself and `out_rdy` rises. The consumer accepts that word by pulling the read enable and both output gates low on a read-clock edge.

The read and write pointers cross between the domains in Gray code through a chain of synchronizer flops. The write domain computes two occupancy indications from its view of the fill level. The half-full flag is one. The other is a combined "almost full or almost empty" flag whose margin can be reprogrammed from the data input. The reset pin may change with no relation to either clock. It acts on each domain at that domain's clock edges, so it must stay low across several edges of both clocks. The flags used for handshaking stay low for a short settling period after reset is released.

"Fill level" below means the number of words in storage, not counting the word held in the output register. The storage holds 256 words. Together with the output register, the block can hold 257 words.

Top module: `dual_clk_fwft_fifo`

## Requirements
- R1: While `rst_n` is low across at least four rising edges of each clock, `in_rdy`, `out_rdy` and `half_full` go low and `af_ae` goes high.
- R2: After `rst_n` rises, `in_rdy` stays low through the first two rising write-clock edges, and `out_rdy` stays low through the first two rising read-clock edges. `in_rdy` rises at the third write-clock edge when storage is not full.
- R3: A word is stored at a rising write-clock edge only when `wr_en_hi` is 1, `wr_en_lo_n` is 0, `in_rdy` is 1 and `cfg_load` is 0. Any other combination stores nothing.
- R4: When storage holds a word and the output register is empty, the word moves into `rd_dout` and `out_rdy` rises, whatever the levels of `rd_en_n`, `oe_a_n` and `oe_b_n`.
- R5: The word in the output register is consumed at a rising read-clock edge only when `rd_en_n`, `oe_a_n` and `oe_b_n` are all 0 and `out_rdy` is 1. Otherwise `rd_dout` and `out_rdy` hold. After a word is consumed, the next stored word (if any) is presented at that same edge. If none is stored, `out_rdy` falls.
- R6: Words leave in the order they were accepted, with none lost, duplicated or altered, under any clock ratio and any pattern of enables.
- R7: With no reads, exactly 257 words are accepted: 256 in storage and 1 in the output register. `in_rdy` then stays low, and the fill level never exceeds 256.
- R8: `half_full` is 1 when the fill level is 129 or more, and 0 when it is 128 or less.
- R9: `af_ae` is 1 when the fill level is at or below the margin, or at or above 256 minus the margin. Otherwise it is 0. The margin is 32 after reset.
- R10: At a rising write-clock edge with `cfg_load` high, the margin is loaded from `wr_din[7:0]` and no word is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock, free running |
| rclk | input | 1 | Read-domain clock, free running |
| rst_n | input | 1 | Active-low reset, applied at each domain's clock edges |
| wr_din | input | 18 | Word to store; bits 7:0 also carry the margin on a load |
| wr_en_hi | input | 1 | Write qualifier, active high |
| wr_en_lo_n | input | 1 | Write qualifier, active low |
| cfg_load | input | 1 | Loads the almost-full/almost-empty margin |
| in_rdy | output | 1 | Room available, write-clock synchronous |
| rd_dout | output | 18 | Output register contents |
| rd_en_n | input | 1 | Read enable, active low |
| oe_a_n | input | 1 | First output gate, active low |
| oe_b_n | input | 1 | Second output gate, active low |
| out_rdy | output | 1 | Output register holds a valid word, read-clock synchronous |
| half_full | output | 1 | Fill level at 129 or more |
| af_ae | output | 1 | Fill level within the margin of either end |

## Verification
The bench builds the block with its default parameters: 18-bit words, 8 address bits (256 entries), two synchronizer stages and a margin of 32. At this depth, storage fills in a few hundred cycles. Every flag edge can therefore be reached by writing an exact count and letting the pointers settle: the half-full step between 128 and 129, both almost thresholds at 32/33 and 223/224, a reprogrammed margin of 10, and the 257-word capacity. The two clocks have periods of 4 ns and 6.8 ns. Their phase keeps drifting, so the random phases, with slow and fast readers, exercise pointer crossing and back-pressure at many relative phases.

// File: rtl/dcf_pkg.sv
// Shared definitions for the dual-clock FIFO.
// Assumes: every module includes this package before it is used.
package dcf_pkg;
    localparam int DATA_W_DEF  = 18;
    localparam int ADDR_W_DEF  = 8;
    localparam int SYNC_N_DEF  = 2;
    localparam int MARGIN_DEF  = 32;

    // Post-reset settling sequence, run separately in each clock domain.
    typedef enum logic [1:0] {
        ST_COLD = 2'd0,
        ST_WARM = 2'd1,
        ST_LIVE = 2'd2
    } settle_e;
endpackage

// File: rtl/dcf_sync.sv
// Multi-flop synchronizer that carries a Gray-coded pointer into another clock domain.
// Assumes: at most one bit of the input changes between source clock edges.
module dcf_sync #(
    parameter int W      = 9,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Shift the pointer one flop further down the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg[s] <= '0;
            end else if (s == 0) begin
                stg[s] <= d;
            end else begin
                stg[s] <= stg[(s == 0) ? 0 : s - 1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_store.sv
// Word storage: one write port in the write domain, and an unregistered read port
// whose address comes from the read domain.
// Assumes: a location is read only after its write pointer has crossed domains.
module dcf_store #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 8
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Commit a qualified word into its slot.
    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_ctrl.sv
// Write-domain control: qualifies writes, keeps the write pointer, and derives
// in_rdy, half-full and the almost-full/almost-empty flag from its view of the
// fill level. It also holds the programmable margin.
// Assumes: rgray_s is the read pointer in Gray code, already synchronized to wclk.
module dcf_wr_ctrl
    import dcf_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int MARGIN = 32
) (
    input  logic              wclk,
    input  logic              rst_n,
    input  logic              wr_en_hi,
    input  logic              wr_en_lo_n,
    input  logic              cfg_load,
    input  logic [ADDR_W-1:0] cfg_val,
    input  logic [ADDR_W:0]   rgray_s,
    output logic              push,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wgray,
    output logic              in_rdy,
    output logic              half_full,
    output logic              af_ae
);
    localparam int PTR_W    = ADDR_W + 1;
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int HALF_THR = DEPTH / 2 + 1;

    settle_e            settle_q;
    logic [PTR_W-1:0]   wbin_q, wbin_nxt, rq_bin, fill_now, fill_nxt, hi_lim, margin_x;
    logic [ADDR_W-1:0]  margin_q;
    logic               in_rdy_q, hf_q, afae_q;

    // Decode the synchronized Gray read pointer back into binary.
    always_comb begin
        for (int i = 0; i < PTR_W; i++) begin
            rq_bin[i] = ^(rgray_s >> i);
        end
    end

    assign push     = wr_en_hi & ~wr_en_lo_n & in_rdy_q & ~cfg_load;
    assign wbin_nxt = wbin_q + PTR_W'(push);
    assign fill_now = wbin_q - rq_bin;
    assign fill_nxt = wbin_nxt - rq_bin;
    assign margin_x = {1'b0, margin_q};
    assign hi_lim   = PTR_W'(DEPTH) - margin_x;

    // Count the settling edges after reset release.
    always_ff @(posedge wclk) begin
        if (!rst_n)                  settle_q <= ST_COLD;
        else if (settle_q == ST_COLD) settle_q <= ST_WARM;
        else                          settle_q <= ST_LIVE;
    end

    // Advance the binary pointer and publish its Gray form.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wbin_q <= '0;
            wgray  <= '0;
        end else begin
            wbin_q <= wbin_nxt;
            wgray  <= wbin_nxt ^ (wbin_nxt >> 1);
        end
    end

    // Load the almost-full/almost-empty margin on request.
    always_ff @(posedge wclk) begin
        if (!rst_n)        margin_q <= ADDR_W'(MARGIN);
        else if (cfg_load) margin_q <= cfg_val;
    end

    // Register room and occupancy flags from the post-edge fill level.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            in_rdy_q <= 1'b0;
            hf_q     <= 1'b0;
            afae_q   <= 1'b1;
        end else begin
            in_rdy_q <= (settle_q == ST_LIVE) && (fill_nxt != PTR_W'(DEPTH));
            hf_q     <= fill_nxt >= PTR_W'(HALF_THR);
            afae_q   <= (fill_nxt <= margin_x) || (fill_nxt >= hi_lim);
        end
    end

    assign waddr     = wbin_q[ADDR_W-1:0];
    assign in_rdy    = in_rdy_q;
    assign half_full = hf_q;
    assign af_ae     = afae_q;

    // R7: the fill level seen by the writer never passes the storage size
    p_no_overflow_r7: assert property (@(posedge wclk) disable iff (!rst_n)
        fill_now <= PTR_W'(DEPTH));
    // R7: a word is never committed into full storage
    p_push_room_r7: assert property (@(posedge wclk) disable iff (!rst_n)
        push |-> (fill_now < PTR_W'(DEPTH)));
    // R2: no room is reported at the first edge after reset release
    p_wr_settle_r2: assert property (@(posedge wclk) disable iff (!rst_n)
        $past(!rst_n) |-> !in_rdy_q);
    // R10: a margin load edge leaves the write pointer alone
    p_cfg_nowrite_r10: assert property (@(posedge wclk) disable iff (!rst_n)
        cfg_load |=> $stable(wbin_q));
endmodule

// File: rtl/dcf_rd_ctrl.sv
// Read-domain control: keeps the read pointer, moves the oldest stored word into
// the output register whenever it is empty or being consumed, and drives out_rdy.
// Assumes: wgray_s is the write pointer in Gray code, already synchronized to rclk.
module dcf_rd_ctrl
    import dcf_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 8
) (
    input  logic              rclk,
    input  logic              rst_n,
    input  logic [ADDR_W:0]   wgray_s,
    input  logic [DATA_W-1:0] ram_data,
    input  logic              rd_en_n,
    input  logic              oe_a_n,
    input  logic              oe_b_n,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic [DATA_W-1:0] dout,
    output logic              out_rdy
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    settle_e            settle_q;
    logic [PTR_W-1:0]   rbin_q, rbin_nxt, wq_bin;
    logic [DATA_W-1:0]  dout_q;
    logic               rdy_q, ram_empty, pop, load;

    // Decode the synchronized Gray write pointer back into binary.
    always_comb begin
        for (int i = 0; i < PTR_W; i++) begin
            wq_bin[i] = ^(wgray_s >> i);
        end
    end

    assign ram_empty = (rbin_q == wq_bin);
    assign pop       = rdy_q & ~rd_en_n & ~oe_a_n & ~oe_b_n;
    assign load      = (settle_q == ST_LIVE) & ~ram_empty & (~rdy_q | pop);
    assign rbin_nxt  = rbin_q + PTR_W'(load);

    // Count the settling edges after reset release.
    always_ff @(posedge rclk) begin
        if (!rst_n)                  settle_q <= ST_COLD;
        else if (settle_q == ST_COLD) settle_q <= ST_WARM;
        else                          settle_q <= ST_LIVE;
    end

    // Advance the read pointer and publish its Gray form.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rbin_q <= '0;
            rgray  <= '0;
        end else begin
            rbin_q <= rbin_nxt;
            rgray  <= rbin_nxt ^ (rbin_nxt >> 1);
        end
    end

    // Fill the output register, or drop its valid flag once it has been consumed.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            dout_q <= '0;
            rdy_q  <= 1'b0;
        end else if (load) begin
            dout_q <= ram_data;
            rdy_q  <= 1'b1;
        end else if (pop) begin
            rdy_q  <= 1'b0;
        end
    end

    assign raddr   = rbin_q[ADDR_W-1:0];
    assign dout    = dout_q;
    assign out_rdy = rdy_q;

    // R5: an unconsumed word stays put and stays valid
    p_hold_r5: assert property (@(posedge rclk) disable iff (!rst_n)
        (rdy_q && !pop) |=> ($stable(dout_q) && rdy_q));
    // R4: the output becomes valid only when storage had a word to give
    p_fill_src_r4: assert property (@(posedge rclk) disable iff (!rst_n)
        $rose(rdy_q) |-> $past(!ram_empty));
    // R2: no valid output at the first edge after reset release
    p_rd_settle_r2: assert property (@(posedge rclk) disable iff (!rst_n)
        $past(!rst_n) |-> !rdy_q);
    // R6: the reader never runs ahead of the synchronized writer
    p_no_underrun_r6: assert property (@(posedge rclk) disable iff (!rst_n)
        (wq_bin - rbin_q) <= PTR_W'(DEPTH));
endmodule

// File: rtl/dual_clk_fwft_fifo.sv
// Top level of the dual-clock first-word-fall-through FIFO: the write control,
// the storage, the read control, and one pointer synchronizer in each direction.
// Assumes: rst_n stays low across at least four edges of each clock, and DATA_W >= ADDR_W.
module dual_clk_fwft_fifo
    import dcf_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int SYNC_N = SYNC_N_DEF,
    parameter int MARGIN = MARGIN_DEF
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_din,
    input  logic              wr_en_hi,
    input  logic              wr_en_lo_n,
    input  logic              cfg_load,
    output logic              in_rdy,
    output logic [DATA_W-1:0] rd_dout,
    input  logic              rd_en_n,
    input  logic              oe_a_n,
    input  logic              oe_b_n,
    output logic              out_rdy,
    output logic              half_full,
    output logic              af_ae
);
    localparam int PTR_W = ADDR_W + 1;

    logic              push;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [PTR_W-1:0]  wgray, rgray, wgray_s, rgray_s;
    logic [DATA_W-1:0] ram_data;

    dcf_wr_ctrl #(.ADDR_W(ADDR_W), .MARGIN(MARGIN)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .wr_en_hi(wr_en_hi), .wr_en_lo_n(wr_en_lo_n),
        .cfg_load(cfg_load), .cfg_val(wr_din[ADDR_W-1:0]), .rgray_s(rgray_s),
        .push(push), .waddr(waddr), .wgray(wgray), .in_rdy(in_rdy),
        .half_full(half_full), .af_ae(af_ae)
    );

    dcf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .wclk(wclk), .we(push), .waddr(waddr), .wdata(wr_din),
        .raddr(raddr), .rdata(ram_data)
    );

    dcf_sync #(.W(PTR_W), .STAGES(SYNC_N)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
    );

    dcf_sync #(.W(PTR_W), .STAGES(SYNC_N)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
    );

    dcf_rd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .wgray_s(wgray_s), .ram_data(ram_data),
        .rd_en_n(rd_en_n), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .raddr(raddr), .rgray(rgray), .dout(rd_dout), .out_rdy(out_rdy)
    );
endmodule

// File: tb/dual_clk_fwft_fifo_tb_top.sv
`timescale 1ns/100ps
module dual_clk_fwft_fifo_tb_top;
    logic        wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
    logic [17:0] wr_din = '0;
    logic        wr_en_hi = 1'b0, wr_en_lo_n = 1'b1, cfg_load = 1'b0;
    logic        rd_en_n = 1'b1, oe_a_n = 1'b1, oe_b_n = 1'b1;
    logic        in_rdy, out_rdy, half_full, af_ae;
    logic [17:0] rd_dout;

    int n_chk = 0, n_bad = 0;
    logic [17:0] q[$];

    always #2   wclk = ~wclk;
    always #3.4 rclk = ~rclk;

    dual_clk_fwft_fifo dut_i (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_din(wr_din),
        .wr_en_hi(wr_en_hi), .wr_en_lo_n(wr_en_lo_n), .cfg_load(cfg_load),
        .in_rdy(in_rdy), .rd_dout(rd_dout), .rd_en_n(rd_en_n),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .out_rdy(out_rdy),
        .half_full(half_full), .af_ae(af_ae)
    );

    function automatic logic exp_hf(int fill);
        return fill >= 129;
    endfunction

    function automatic logic exp_afae(int fill, int margin);
        return (fill <= margin) || (fill >= 256 - margin);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h, want %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en_hi = 0; wr_en_lo_n = 1; cfg_load = 0;
        rd_en_n = 1; oe_a_n = 1; oe_b_n = 1;
        repeat (6) @(negedge wclk);
        #30;
        @(negedge wclk);
        chk("R1 in_rdy", 32'(in_rdy), 0);
        chk("R1 out_rdy", 32'(out_rdy), 0);
        chk("R1 half_full", 32'(half_full), 0);
        chk("R1 af_ae", 32'(af_ae), 1);
        rst_n = 1'b1;
    endtask

    task automatic settle();
        repeat (30) @(negedge wclk);
    endtask

    task automatic push_word(input logic [17:0] v);
        bit done = 0;
        while (!done) begin
            @(negedge wclk);
            wr_en_hi = 1; wr_en_lo_n = 0; wr_din = v;
            done = in_rdy;
        end
    endtask

    task automatic wr_idle();
        @(negedge wclk);
        wr_en_hi = 0; wr_en_lo_n = 1;
    endtask

    task automatic fill_case(input int n, input bit load, input int margin);
        int fill;
        do_reset();
        repeat (8) @(negedge wclk);
        if (load) begin
            @(negedge wclk); cfg_load = 1; wr_din = 18'(margin);
            @(negedge wclk); cfg_load = 0;
        end
        for (int i = 0; i < n; i++) push_word(18'(i + 7));
        wr_idle();
        settle();
        fill = (n > 0) ? n - 1 : 0;
        chk("R8 half_full", 32'(half_full), 32'(exp_hf(fill)));
        chk(load ? "R10 af_ae margin" : "R9 af_ae", 32'(af_ae), 32'(exp_afae(fill, margin)));
        chk("R4 out_rdy after fill", 32'(out_rdy), 32'(n > 0));
        if (n == 257) chk("R7 in_rdy when full", 32'(in_rdy), 0);
    endtask

    // Watchdog: a hang counts as a failure and still ends with the summary.
    initial begin
        repeat (190000) @(posedge wclk);
        n_bad++;
        $display("FAIL watchdog: got timeout, want completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int acc, idx;
        void'($urandom(32'd20240611));

        // R2: settling of in_rdy after release
        do_reset();
        @(negedge wclk); chk("R2 in_rdy edge1", 32'(in_rdy), 0);
        @(negedge wclk); chk("R2 in_rdy edge2", 32'(in_rdy), 0);
        @(negedge wclk); chk("R2 in_rdy edge3", 32'(in_rdy), 1);
        chk("R2 out_rdy empty", 32'(out_rdy), 0);

        // R3 / R10: unqualified writes and a margin load store nothing
        repeat (8) @(negedge wclk);
        @(negedge wclk); wr_en_hi = 0; wr_en_lo_n = 0; wr_din = 18'h11111;
        repeat (4) @(negedge wclk);
        wr_en_hi = 1; wr_en_lo_n = 1;
        repeat (4) @(negedge wclk);
        wr_en_hi = 0; wr_en_lo_n = 1;
        repeat (4) @(negedge wclk);
        wr_en_hi = 1; wr_en_lo_n = 0; cfg_load = 1; wr_din = 18'd32;
        @(negedge wclk); wr_en_hi = 0; wr_en_lo_n = 1; cfg_load = 0;
        settle();
        chk("R3 nothing stored", 32'(out_rdy), 0);
        chk("R10 load stores no word", 32'(af_ae), 1);

        // R4: fall-through without any read enable
        push_word(18'h2A5A5); wr_idle();
        push_word(18'h15A5A); wr_idle();
        settle();
        chk("R4 out_rdy", 32'(out_rdy), 1);
        chk("R4 rd_dout", 32'(rd_dout), 32'h2A5A5);

        // R5: each single gate high blocks consumption
        @(negedge rclk); rd_en_n = 0; oe_a_n = 1; oe_b_n = 0;
        repeat (5) @(negedge rclk);
        rd_en_n = 0; oe_a_n = 0; oe_b_n = 1;
        repeat (5) @(negedge rclk);
        rd_en_n = 1; oe_a_n = 0; oe_b_n = 0;
        repeat (5) @(negedge rclk);
        chk("R5 hold data", 32'(rd_dout), 32'h2A5A5);
        chk("R5 hold valid", 32'(out_rdy), 1);
        rd_en_n = 0;
        @(negedge rclk); rd_en_n = 1;
        chk("R5 next word presented", 32'(rd_dout), 32'h15A5A);
        chk("R5 still valid", 32'(out_rdy), 1);
        rd_en_n = 0;
        @(negedge rclk); rd_en_n = 1;
        chk("R5 valid drops when drained", 32'(out_rdy), 0);

        // R8 / R9 / R7: exact fill levels around each threshold
        fill_case(1, 0, 32);
        fill_case(33, 0, 32);
        fill_case(34, 0, 32);
        fill_case(129, 0, 32);
        fill_case(130, 0, 32);
        fill_case(224, 0, 32);
        fill_case(225, 0, 32);
        fill_case(257, 0, 32);
        // R10: reprogrammed margin of 10
        fill_case(11, 1, 10);
        fill_case(12, 1, 10);
        fill_case(246, 1, 10);
        fill_case(247, 1, 10);

        // R7: capacity with no reads, then R6 order on drain
        do_reset();
        repeat (8) @(negedge wclk);
        acc = 0;
        for (int c = 0; c < 400; c++) begin
            @(negedge wclk);
            wr_en_hi = 1; wr_en_lo_n = 0; wr_din = 18'(acc);
            if (in_rdy) acc++;
        end
        wr_idle();
        chk("R7 words accepted", 32'(acc), 257);
        idx = 0;
        for (int c = 0; c < 3000 && idx < 257; c++) begin
            @(negedge rclk);
            if (out_rdy) begin
                chk("R6 drain order", 32'(rd_dout), 32'(idx));
                idx++;
            end
            rd_en_n = 0; oe_a_n = 0; oe_b_n = 0;
        end
        @(negedge rclk); rd_en_n = 1; oe_a_n = 1; oe_b_n = 1;
        chk("R6 drain count", 32'(idx), 257);

        // R6 / R3 / R5: random traffic with slow and fast reader phases
        do_reset();
        repeat (8) @(negedge wclk);
        fork
            begin : writer
                int sent = 0;
                while (sent < 3000) begin
                    int r;
                    @(negedge wclk);
                    r = int'($urandom % 8);
                    if (r < 5) begin
                        wr_en_hi = 1; wr_en_lo_n = 0; wr_din = 18'($urandom);
                        if (in_rdy) begin q.push_back(wr_din); sent++; end
                    end else begin
                        wr_en_hi = (r != 5); wr_en_lo_n = (r != 5);
                        wr_din = 18'($urandom);
                    end
                end
                @(negedge wclk); wr_en_hi = 0; wr_en_lo_n = 1;
            end
            begin : reader
                int got = 0;
                while (got < 3000) begin
                    bit fast, all;
                    @(negedge rclk);
                    fast = ((got / 500) % 2) == 1;
                    all = int'($urandom % 10) < (fast ? 9 : 3);
                    if (all) begin
                        rd_en_n = 0; oe_a_n = 0; oe_b_n = 0;
                        if (out_rdy) begin
                            logic [17:0] e;
                            e = (q.size() > 0) ? q.pop_front() : 18'h0;
                            chk("R6 random order", 32'(rd_dout), 32'(e));
                            got++;
                        end
                    end else begin
                        logic [2:0] g;
                        g = 3'(($urandom % 7) + 1);
                        rd_en_n = g[0]; oe_a_n = g[1]; oe_b_n = g[2];
                    end
                end
                @(negedge rclk); rd_en_n = 1; oe_a_n = 1; oe_b_n = 1;
            end
        join
        settle();
        chk("R6 nothing left over", 32'(out_rdy), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule